// File: doc/BRIEF.md
# Vector Floating-Point Compare Unit

This block compares each element of a floating-point source vector against either the matching element of a second vector or one scalar broadcast to every lane. It writes one result bit per element into a destination mask. Elements may be 16, 32 or 64 bits wide, in the standard binary interchange formats. Seven relations are available: equal, not-equal, less, less-or-equal, greater, greater-or-equal and ordered.

A caller presents the instruction fields, the element width, the active length `vl`, the group size `vlmax`, both source registers, the scalar, the `v0` mask and the current destination mask, and then pulses `start`. The unit captures everything on that edge. It then handles one element per clock and pulses `done` once the last element is in `vd_mask`.

An element is skipped when masking is enabled and its `v0` bit is clear. Elements from `vl` to `vlmax-1` are cleared. A sticky invalid-operation flag collects exceptions until `flag_clr` is asserted.

Top module: `vfc_unit`

## Requirements
- R1: A start is accepted only when `op_major` is 1010111 and `op_funct3` is 001 (vector-vector, second operand from `vs1_data`) or 101 (vector-scalar, second operand from `scalar`). `op_funct6` selects the relation: 011000 eq, 011100 ne, 011011 lt, 011001 le, 011101 gt, 011111 ge, 011010 ord. Any other encoding raises `illegal`, pulses `done` one cycle after `start`, and leaves `vd_mask` and `invalid_flag` unchanged.
- R2: gt (011101) and ge (011111) are legal only with funct3 101. With funct3 001 they are rejected as described in R1.
- R3: `sew` 00 selects 8-bit elements and is always rejected. 01, 10 and 11 select 16, 32 and 64 bits.
- R4: The first operand of element i is `vs2_data[i*SEW +: SEW]`. The second operand is `vs1_data[i*SEW +: SEW]`, or the low SEW bits of `scalar`, whose upper bits are ignored.
- R5: eq, ne and ord are quiet compares. +0 and -0 are equal. With a NaN operand, eq and ord give 0 and ne gives 1.
- R6: lt, le, gt and ge follow numeric order, including infinities and subnormals. le and ge also hold on equality. Any NaN operand gives 0.
- R7: `invalid_flag` is sticky. It is set by an active element when a signalling relation (lt, le, gt, ge) sees any NaN, or when a quiet relation sees a signalling NaN (exponent all ones, mantissa non-zero, mantissa MSB 0). `flag_clr` clears it, except that a set in the same cycle wins.
- R8: When `op_vm` is 0 and `v0_mask[i]` is 0, bit i of `vd_mask` keeps its `vd_old` value and cannot set the flag.
- R9: For `vl` <= i < `vlmax`, bit i is written 0 and cannot set the flag. Bits at or above `vlmax` keep their `vd_old` value.
- R10: After the `start` edge, one element is handled per clock. `done` goes high for exactly one cycle, `vlmax` cycles after the first element, i.e. on the cycle after the edge that writes element `vlmax-1`. It follows the start edge directly when `vlmax` is 0 or the start is illegal. `busy` is high while elements are being processed, and `start` is ignored while `busy` is high.
- R11: A legal start loads `vd_old` into `vd_mask`. The mask holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a compare; accepted only when not busy |
| op_funct6 | input | 6 | Relation selector field |
| op_vm | input | 1 | 1 = unmasked, 0 = use v0_mask |
| op_funct3 | input | 3 | Operand form field |
| op_major | input | 7 | Major opcode field |
| sew | input | 2 | Element width code |
| vl | input | IDX_W | Active element count |
| vlmax | input | IDX_W | Elements in the register group |
| vs2_data | input | VLEN | First source vector |
| vs1_data | input | VLEN | Second source vector |
| scalar | input | 64 | Broadcast scalar operand |
| v0_mask | input | MAX_ELEMS | Element enable mask |
| vd_old | input | MAX_ELEMS | Previous destination mask |
| flag_clr | input | 1 | Clear the invalid flag |
| busy | output | 1 | Elements being processed |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Last start was rejected |
| vd_mask | output | MAX_ELEMS | Destination mask |
| invalid_flag | output | 1 | Sticky invalid-operation flag |

## Verification
Some properties are checked on every cycle. These are: a masked-off element leaves its destination bit untouched, a tail element always clears its bit, `done` is a single pulse that never coincides with `busy`, the flag cannot rise outside a processing cycle and stays set until cleared, and an 8-bit element width is always rejected. The numeric results cannot be seen from the control state: the per-format ordering, signed zeros, infinities, subnormals, quiet versus signalling NaNs, scalar truncation and the exact latency. These are covered only by the bench's sweeps. The bench computes each expected bit from real-valued arithmetic on every pairing of a pool of special values.

// File: rtl/vfc_pkg.sv
package vfc_pkg;

  typedef enum logic [2:0] {
    REL_EQ  = 3'd0,
    REL_NE  = 3'd1,
    REL_LT  = 3'd2,
    REL_LE  = 3'd3,
    REL_GT  = 3'd4,
    REL_GE  = 3'd5,
    REL_ORD = 3'd6
  } rel_e;

  typedef enum logic [1:0] {
    EW_8  = 2'd0,
    EW_16 = 2'd1,
    EW_32 = 2'd2,
    EW_64 = 2'd3
  } ew_e;

  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_e;

  localparam logic [6:0] OPC_VEC    = 7'b1010111;
  localparam logic [2:0] F3_VECVEC  = 3'b001;
  localparam logic [2:0] F3_VECSCL  = 3'b101;
  localparam logic [5:0] F6_EQ      = 6'b011000;
  localparam logic [5:0] F6_NE      = 6'b011100;
  localparam logic [5:0] F6_LT      = 6'b011011;
  localparam logic [5:0] F6_LE      = 6'b011001;
  localparam logic [5:0] F6_GT      = 6'b011101;
  localparam logic [5:0] F6_GE      = 6'b011111;
  localparam logic [5:0] F6_ORD     = 6'b011010;

  typedef struct packed {
    logic legal;
    logic scalar_src;
    logic unmasked;
    rel_e rel;
  } cmd_s;

  // Ordering relations raise invalid on any NaN; the rest only on signalling NaNs.
  function automatic logic rel_is_signalling(rel_e r);
    return (r == REL_LT) || (r == REL_LE) || (r == REL_GT) || (r == REL_GE);
  endfunction

endpackage

// File: rtl/vfc_decode.sv
module vfc_decode
  import vfc_pkg::*;
(
  input  logic [5:0] funct6,
  input  logic       vm,
  input  logic [2:0] funct3,
  input  logic [6:0] major,
  input  ew_e        ew,
  output cmd_s       cmd
);

  rel_e rel;
  logic rel_ok;
  logic form_ok;
  logic scalar_form;
  logic needs_scalar;

  always_comb begin
    rel    = REL_EQ;
    rel_ok = 1'b1;
    case (funct6)
      F6_EQ:   rel = REL_EQ;
      F6_NE:   rel = REL_NE;
      F6_LT:   rel = REL_LT;
      F6_LE:   rel = REL_LE;
      F6_GT:   rel = REL_GT;
      F6_GE:   rel = REL_GE;
      F6_ORD:  rel = REL_ORD;
      default: rel_ok = 1'b0;
    endcase
  end

  assign scalar_form  = (funct3 == F3_VECSCL);
  assign form_ok      = (major == OPC_VEC) && ((funct3 == F3_VECVEC) || scalar_form);
  assign needs_scalar = (rel == REL_GT) || (rel == REL_GE);

  always_comb begin
    cmd            = '0;
    cmd.rel        = rel;
    cmd.scalar_src = scalar_form;
    cmd.unmasked   = vm;
    cmd.legal      = form_ok && rel_ok && (!needs_scalar || scalar_form) && (ew != EW_8);
  end

endmodule

// File: rtl/vfc_fp_rel.sv
module vfc_fp_rel #(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] lhs,
  input  logic [EXP_W+MAN_W:0] rhs,
  output logic                 is_eq,
  output logic                 is_lt,
  output logic                 unord,
  output logic                 snan_seen
);

  localparam int MAG_W = EXP_W + MAN_W;

  logic             sign_l, sign_r;
  logic [MAG_W-1:0] mag_l, mag_r;
  logic             nan_l, nan_r, snan_l, snan_r;
  logic             both_zero;

  assign sign_l = lhs[MAG_W];
  assign sign_r = rhs[MAG_W];
  assign mag_l  = lhs[MAG_W-1:0];
  assign mag_r  = rhs[MAG_W-1:0];

  assign nan_l  = (&lhs[MAG_W-1:MAN_W]) && (|lhs[MAN_W-1:0]);
  assign nan_r  = (&rhs[MAG_W-1:MAN_W]) && (|rhs[MAN_W-1:0]);
  assign snan_l = nan_l && !lhs[MAN_W-1];
  assign snan_r = nan_r && !rhs[MAN_W-1];

  assign unord     = nan_l || nan_r;
  assign snan_seen = snan_l || snan_r;
  assign both_zero = (mag_l == '0) && (mag_r == '0);

  assign is_eq = !unord && ((lhs == rhs) || both_zero);

  always_comb begin
    if (unord || both_zero) begin
      is_lt = 1'b0;
    end else if (sign_l != sign_r) begin
      is_lt = sign_l;
    end else if (!sign_l) begin
      is_lt = (mag_l < mag_r);
    end else begin
      is_lt = (mag_l > mag_r);
    end
  end

endmodule

// File: rtl/vfc_elem_cmp.sv
module vfc_elem_cmp
  import vfc_pkg::*;
(
  input  ew_e         ew,
  input  rel_e        rel,
  input  logic [63:0] lhs,
  input  logic [63:0] rhs,
  output logic        result,
  output logic        invalid
);

  localparam int NFMT = 3;

  logic [NFMT-1:0] eq_v, lt_v, un_v, sn_v;

  for (genvar g = 0; g < NFMT; g++) begin : g_fmt
    localparam int EW = (g == 0) ? 5  : (g == 1) ? 8  : 11;
    localparam int MW = (g == 0) ? 10 : (g == 1) ? 23 : 52;
    localparam int W  = EW + MW + 1;
    vfc_fp_rel #(.EXP_W(EW), .MAN_W(MW)) u_rel (
      .lhs      (lhs[W-1:0]),
      .rhs      (rhs[W-1:0]),
      .is_eq    (eq_v[g]),
      .is_lt    (lt_v[g]),
      .unord    (un_v[g]),
      .snan_seen(sn_v[g])
    );
  end

  logic f_eq, f_lt, f_un, f_sn;

  always_comb begin
    case (ew)
      EW_32:   begin f_eq = eq_v[1]; f_lt = lt_v[1]; f_un = un_v[1]; f_sn = sn_v[1]; end
      EW_64:   begin f_eq = eq_v[2]; f_lt = lt_v[2]; f_un = un_v[2]; f_sn = sn_v[2]; end
      default: begin f_eq = eq_v[0]; f_lt = lt_v[0]; f_un = un_v[0]; f_sn = sn_v[0]; end
    endcase
  end

  always_comb begin
    case (rel)
      REL_EQ:  result = f_eq;
      REL_NE:  result = !f_eq;
      REL_LT:  result = f_lt;
      REL_LE:  result = f_lt || f_eq;
      REL_GT:  result = !(f_lt || f_eq || f_un);
      REL_GE:  result = !(f_lt || f_un);
      default: result = !f_un;
    endcase
  end

  assign invalid = rel_is_signalling(rel) ? f_un : f_sn;

endmodule

// File: rtl/vfc_unit.sv
module vfc_unit
  import vfc_pkg::*;
#(
  parameter int VLEN    = 128,
  parameter int MIN_SEW = 16,
  localparam int MAX_ELEMS = VLEN / MIN_SEW,
  localparam int IDX_W     = $clog2(MAX_ELEMS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic [5:0]           op_funct6,
  input  logic                 op_vm,
  input  logic [2:0]           op_funct3,
  input  logic [6:0]           op_major,
  input  logic [1:0]           sew,
  input  logic [IDX_W-1:0]     vl,
  input  logic [IDX_W-1:0]     vlmax,
  input  logic [VLEN-1:0]      vs2_data,
  input  logic [VLEN-1:0]      vs1_data,
  input  logic [63:0]          scalar,
  input  logic [MAX_ELEMS-1:0] v0_mask,
  input  logic [MAX_ELEMS-1:0] vd_old,
  input  logic                 flag_clr,
  output logic                 busy,
  output logic                 done,
  output logic                 illegal,
  output logic [MAX_ELEMS-1:0] vd_mask,
  output logic                 invalid_flag
);

  // VLEN is expected to be at least 64 so a full 64-bit element fits.
  localparam int SEL_W = (MAX_ELEMS > 1) ? $clog2(MAX_ELEMS) : 1;
  localparam int SH_W  = IDX_W + 6;

  cmd_s cmd_in, cmd_q;
  ew_e  ew_in, ew_q;

  phase_e               phase_q;
  logic [IDX_W-1:0]     idx_q, last_q, vl_q;
  logic [VLEN-1:0]      src2_q, src1_q;
  logic [63:0]          scalar_q;
  logic [MAX_ELEMS-1:0] v0_q, dst_q;
  logic                 done_q, illegal_q, flag_q;

  assign ew_in = ew_e'(sew);

  vfc_decode u_decode (
    .funct6(op_funct6),
    .vm    (op_vm),
    .funct3(op_funct3),
    .major (op_major),
    .ew    (ew_in),
    .cmd   (cmd_in)
  );

  // Element selection: shift by index times element width.
  logic [SEL_W-1:0] sel;
  logic [SH_W-1:0]  shamt;
  logic [63:0]      lhs, rhs;

  assign sel   = idx_q[SEL_W-1:0];
  assign shamt = SH_W'(idx_q) << ({1'b0, ew_q} + 3'd3);
  assign lhs   = 64'(src2_q >> shamt);
  assign rhs   = cmd_q.scalar_src ? scalar_q : 64'(src1_q >> shamt);

  logic cmp_bit, cmp_inv;

  vfc_elem_cmp u_cmp (
    .ew     (ew_q),
    .rel    (cmd_q.rel),
    .lhs    (lhs),
    .rhs    (rhs),
    .result (cmp_bit),
    .invalid(cmp_inv)
  );

  logic in_body, active, running, flag_set;

  assign running  = (phase_q == PH_RUN);
  assign in_body  = (idx_q < vl_q);
  assign active   = running && in_body && (cmd_q.unmasked || v0_q[sel]);
  assign flag_set = active && cmp_inv;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      idx_q     <= '0;
      last_q    <= '0;
      vl_q      <= '0;
      cmd_q     <= '0;
      ew_q      <= EW_16;
      src2_q    <= '0;
      src1_q    <= '0;
      scalar_q  <= '0;
      v0_q      <= '0;
      dst_q     <= '0;
      done_q    <= 1'b0;
      illegal_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_IDLE: begin
          if (start) begin
            illegal_q <= !cmd_in.legal;
            if (!cmd_in.legal) begin
              done_q <= 1'b1;
            end else begin
              cmd_q    <= cmd_in;
              ew_q     <= ew_in;
              vl_q     <= vl;
              last_q   <= vlmax - IDX_W'(1);
              src2_q   <= vs2_data;
              src1_q   <= vs1_data;
              scalar_q <= scalar;
              v0_q     <= v0_mask;
              dst_q    <= vd_old;
              idx_q    <= '0;
              if (vlmax == '0) begin
                done_q <= 1'b1;
              end else begin
                phase_q <= PH_RUN;
              end
            end
          end
        end
        default: begin
          if (!in_body) begin
            dst_q[sel] <= 1'b0;
          end else if (active) begin
            dst_q[sel] <= cmp_bit;
          end
          if (idx_q == last_q) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end else begin
            idx_q <= idx_q + IDX_W'(1);
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
    end else begin
      flag_q <= (flag_clr ? 1'b0 : flag_q) | flag_set;
    end
  end

  assign busy         = running;
  assign done         = done_q;
  assign illegal      = illegal_q;
  assign vd_mask      = dst_q;
  assign invalid_flag = flag_q;

  // R8: a masked-off element leaves its destination bit untouched
  a_r8_masked_hold: assert property (@(posedge clk) disable iff (rst)
    (running && in_body && !cmd_q.unmasked && !v0_q[sel])
      |=> (vd_mask[$past(sel)] == $past(vd_mask[sel])));

  // R9: a tail element always clears its bit
  a_r9_tail_zero: assert property (@(posedge clk) disable iff (rst)
    (running && !in_body) |=> !vd_mask[$past(sel)]);

  // R10: done is a single-cycle pulse
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> !done);

  // R10: done never overlaps processing
  a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
    !(done && busy));

  // R7: the flag stays set until cleared
  a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
    (invalid_flag && !flag_clr) |=> invalid_flag);

  // R7: the flag can only rise after a processing cycle
  a_r7_rise_only_running: assert property (@(posedge clk) disable iff (rst)
    !busy |=> !$rose(invalid_flag));

  // R11: the mask is stable while idle and no start arrives
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> $stable(vd_mask));

  // R3: an 8-bit element width is rejected
  a_r3_ew8_rejected: assert property (@(posedge clk) disable iff (rst)
    (start && !busy && sew == 2'b00) |=> (illegal && done));

endmodule

// File: tb/vfc_unit_bench.sv
`timescale 1ns/1ps
module vfc_unit_bench;

  localparam int VLEN = 128;
  localparam int NE   = 8;
  localparam int IW   = 4;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            start = 1'b0;
  logic [5:0]      op_funct6 = '0;
  logic            op_vm = 1'b1;
  logic [2:0]      op_funct3 = '0;
  logic [6:0]      op_major = '0;
  logic [1:0]      sew = 2'b01;
  logic [IW-1:0]   vl = '0, vlmax = '0;
  logic [VLEN-1:0] vs2_data = '0, vs1_data = '0;
  logic [63:0]     scalar = '0;
  logic [NE-1:0]   v0_mask = '0, vd_old = '0;
  logic            flag_clr = 1'b0;
  logic            busy, done, illegal, invalid_flag;
  logic [NE-1:0]   vd_mask;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vfc_unit u_vfc_unit (
    .clk(clk), .rst(rst), .start(start),
    .op_funct6(op_funct6), .op_vm(op_vm), .op_funct3(op_funct3), .op_major(op_major),
    .sew(sew), .vl(vl), .vlmax(vlmax),
    .vs2_data(vs2_data), .vs1_data(vs1_data), .scalar(scalar),
    .v0_mask(v0_mask), .vd_old(vd_old), .flag_clr(flag_clr),
    .busy(busy), .done(done), .illegal(illegal),
    .vd_mask(vd_mask), .invalid_flag(invalid_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL R10 watchdog expired: actual 0 expected 1");
    summary();
  end

  function automatic void fmt_of(input int sw, output int ew, output int mw);
    ew = (sw == 16) ? 5 : (sw == 32) ? 8 : 11;
    mw = (sw == 16) ? 10 : (sw == 32) ? 23 : 52;
  endfunction

  function automatic real pow2(input int e);
    real r = 1.0;
    if (e >= 0) for (int k = 0; k < e; k++) r = r * 2.0;
    else        for (int k = 0; k < -e; k++) r = r / 2.0;
    return r;
  endfunction

  function automatic real fp_val(input logic [63:0] x, input int sw);
    int ew, mw, bias, e;
    longint m;
    bit s;
    real r;
    fmt_of(sw, ew, mw);
    bias = (1 << (ew - 1)) - 1;
    e = int'((x >> mw) & ((64'd1 << ew) - 1));
    m = longint'(x & ((64'd1 << mw) - 1));
    s = x[ew + mw];
    if (e == (1 << ew) - 1) r = $bitstoreal(64'h7FF0000000000000);
    else if (e == 0) r = real'(m) * pow2(1 - bias - mw);
    else r = (real'(m) + pow2(mw)) * pow2(e - bias - mw);
    return s ? -r : r;
  endfunction

  function automatic logic [63:0] pool_val(input int sw, input int k);
    int ew, mw;
    logic [63:0] bias, sg, inf;
    fmt_of(sw, ew, mw);
    bias = (64'd1 << (ew - 1)) - 1;
    sg   = 64'd1 << (ew + mw);
    inf  = ((64'd1 << ew) - 1) << mw;
    case (k)
      0: return 64'd0;
      1: return sg;
      2: return bias << mw;
      3: return sg | (bias << mw);
      4: return (bias + 1) << mw;
      5: return inf;
      6: return sg | inf;
      7: return inf | (64'd1 << (mw - 1));
      8: return inf | 64'd1;
      9: return 64'd1;
      default: return sg | (bias << mw) | (64'd1 << (mw - 1));
    endcase
  endfunction

  function automatic void ref_rel(input logic [63:0] a, input logic [63:0] b,
                                  input int sw, input int rel,
                                  output bit r, output bit inv);
    int ew, mw;
    logic [63:0] em, mm;
    bit an, bn, asn, bsn, un, sn;
    real ra, rb;
    fmt_of(sw, ew, mw);
    em = (64'd1 << ew) - 1;
    mm = (64'd1 << mw) - 1;
    an  = (((a >> mw) & em) == em) && ((a & mm) != 0);
    bn  = (((b >> mw) & em) == em) && ((b & mm) != 0);
    asn = an && !a[mw - 1];
    bsn = bn && !b[mw - 1];
    un = an || bn;
    sn = asn || bsn;
    ra = un ? 0.0 : fp_val(a, sw);
    rb = un ? 0.0 : fp_val(b, sw);
    case (rel)
      0: r = !un && (ra == rb);
      1: r = un || (ra != rb);
      2: r = !un && (ra < rb);
      3: r = !un && (ra <= rb);
      4: r = !un && (ra > rb);
      5: r = !un && (ra >= rb);
      default: r = !un;
    endcase
    inv = (rel >= 2 && rel <= 5) ? un : sn;
  endfunction

  function automatic logic [5:0] f6_of(input int rel);
    case (rel)
      0: return 6'b011000;
      1: return 6'b011100;
      2: return 6'b011011;
      3: return 6'b011001;
      4: return 6'b011101;
      5: return 6'b011111;
      default: return 6'b011010;
    endcase
  endfunction

  // Apply one operation and check mask, flag, illegal and latency.
  task automatic run_op(input logic [5:0] f6, input logic [2:0] f3, input logic [6:0] opc,
                        input int sw, input int vln, input int vmx,
                        input logic [VLEN-1:0] s2, input logic [VLEN-1:0] s1,
                        input logic [63:0] sc, input logic [NE-1:0] v0m,
                        input logic [NE-1:0] dold, input bit vmb,
                        input int rel, input bit vf, input bit exp_ill,
                        input bit clr, input bit poke, input string tag);
    logic [NE-1:0] exp_mask, prev_mask;
    bit exp_flag, prev_flag, r, inv, f;
    logic [63:0] em, a, b;
    int cnt, exp_cyc;
    @(negedge clk);
    if (clr) begin
      flag_clr = 1'b1;
      @(negedge clk);
      flag_clr = 1'b0;
    end
    prev_mask = vd_mask;
    prev_flag = invalid_flag;
    em = (sw == 64) ? '1 : ((64'd1 << sw) - 1);
    f = 1'b0;
    exp_mask = dold;
    for (int i = 0; i < vmx; i++) begin
      if (i >= vln) exp_mask[i] = 1'b0;
      else if (vmb || v0m[i]) begin
        a = 64'(s2 >> (i * sw)) & em;
        b = vf ? (sc & em) : (64'(s1 >> (i * sw)) & em);
        ref_rel(a, b, sw, rel, r, inv);
        exp_mask[i] = r;
        f = f | inv;
      end
    end
    if (exp_ill) begin
      exp_mask = prev_mask;
      f = 1'b0;
    end
    exp_flag = prev_flag | f;
    exp_cyc = (exp_ill || vmx == 0) ? 1 : vmx + 1;
    op_funct6 = f6; op_funct3 = f3; op_major = opc; op_vm = vmb;
    sew = (sw == 8) ? 2'b00 : (sw == 16) ? 2'b01 : (sw == 32) ? 2'b10 : 2'b11;
    vl = IW'(vln); vlmax = IW'(vmx);
    vs2_data = s2; vs1_data = s1; scalar = sc; v0_mask = v0m; vd_old = dold;
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    cnt = 1;
    while (!done && cnt < 40) begin
      start = poke && (cnt == 2);
      vs2_data = (poke && cnt == 2) ? ~s2 : s2;
      vd_old = (poke && cnt == 2) ? ~dold : dold;
      @(posedge clk); #1;
      cnt++;
    end
    start = 1'b0;
    vs2_data = s2; vd_old = dold;
    chk(cnt == exp_cyc, "R10", {tag, " done latency"}, cnt, exp_cyc);
    chk(vd_mask == exp_mask, tag, "mask", vd_mask, exp_mask);
    chk(invalid_flag == exp_flag, "R7", {tag, " flag"}, invalid_flag, exp_flag);
    chk(illegal == exp_ill, exp_ill ? "R1" : tag, "illegal", illegal, exp_ill);
    @(posedge clk); #1;
    chk(!done, "R10", {tag, " done pulse width"}, done, 0);
  endtask

  initial begin
    logic [VLEN-1:0] s2, s1;
    logic [63:0] sc, upper;
    int nel;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    chk(!busy && !done, "R10", "reset idle", {busy, done}, 0);
    chk(vd_mask == '0, "R11", "reset mask", vd_mask, 0);
    chk(!invalid_flag && !illegal, "R7", "reset flag", {invalid_flag, illegal}, 0);

    // Exhaustive pool pairings, every width, relation and form (R4 R5 R6).
    for (int sw = 16; sw <= 64; sw = sw * 2) begin
      nel = VLEN / sw;
      upper = (sw == 64) ? 64'd0 : ~((64'd1 << sw) - 1);
      for (int rel = 0; rel < 7; rel++) begin
        string tg;
        tg = (rel == 0 || rel == 1 || rel == 6) ? "R5" : "R6";
        if (rel == 4 || rel == 5) begin
          // R2: greater relations are illegal in vector-vector form
          run_op(f6_of(rel), 3'b001, 7'b1010111, sw, nel, nel, '0, '0, '0, '0, '0,
                 1'b1, rel, 1'b0, 1'b1, 1'b0, 1'b0, "R2");
        end else begin
          for (int p = 0; p < 121; p += nel) begin
            s2 = '0; s1 = '0;
            for (int j = 0; j < nel; j++) begin
              int q;
              q = (p + j) % 121;
              s2 = s2 | (VLEN'(pool_val(sw, q / 11)) << (j * sw));
              s1 = s1 | (VLEN'(pool_val(sw, q % 11)) << (j * sw));
            end
            run_op(f6_of(rel), 3'b001, 7'b1010111, sw, nel, nel, s2, s1, '0, '0, '0,
                   1'b1, rel, 1'b0, 1'b0, 1'b1, 1'b0, tg);
          end
        end
        for (int bi = 0; bi < 11; bi++) begin
          for (int p = 0; p < 11; p += nel) begin
            s2 = '0;
            for (int j = 0; j < nel; j++)
              s2 = s2 | (VLEN'(pool_val(sw, (p + j) % 11)) << (j * sw));
            sc = upper | pool_val(sw, bi);
            run_op(f6_of(rel), 3'b101, 7'b1010111, sw, nel, nel, s2, ~s2, sc, '0, '0,
                   1'b1, rel, 1'b1, 1'b0, 1'b1, 1'b0, (bi == 0) ? "R4" : tg);
          end
        end
      end
    end

    // Masking, tail and destination preload (R8 R9 R11).
    for (int t = 0; t < 80; t++) begin
      int sw, vmx, vln, rel;
      bit vf, vmb;
      sw  = 16 << $urandom_range(0, 2);
      nel = VLEN / sw;
      vmx = $urandom_range(0, nel);
      vln = $urandom_range(0, vmx);
      vf  = 1'($urandom_range(0, 1));
      vmb = 1'($urandom_range(0, 1));
      rel = $urandom_range(0, 6);
      if (!vf && (rel == 4 || rel == 5)) rel = 2;
      s2 = '0; s1 = '0;
      for (int j = 0; j < nel; j++) begin
        s2 = s2 | (VLEN'(pool_val(sw, $urandom_range(0, 10))) << (j * sw));
        s1 = s1 | (VLEN'(pool_val(sw, $urandom_range(0, 10))) << (j * sw));
      end
      sc = pool_val(sw, $urandom_range(0, 10));
      run_op(f6_of(rel), vf ? 3'b101 : 3'b001, 7'b1010111, sw, vln, vmx, s2, s1, sc,
             NE'($urandom), NE'($urandom), vmb, rel, vf, 1'b0, 1'($urandom_range(0, 1)),
             1'b0, "R8 R9 R11");
    end

    // R7: sticky flag survives a clean op without clear.
    run_op(f6_of(2), 3'b101, 7'b1010111, 16, 8, 8, '0, '0, 64'h7E00, '0, '0,
           1'b1, 2, 1'b1, 1'b0, 1'b1, 1'b0, "R7");
    run_op(f6_of(0), 3'b001, 7'b1010111, 16, 8, 8, '0, '0, '0, '0, '0,
           1'b1, 0, 1'b0, 1'b0, 1'b0, 1'b0, "R7");
    chk(invalid_flag, "R7", "sticky after clean op", invalid_flag, 1);

    // Rejected encodings leave mask and flag alone (R1 R2 R3).
    run_op(f6_of(0), 3'b001, 7'b1010111, 8, 8, 8, '1, '0, '0, '0, '1,
           1'b1, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R3");
    run_op(f6_of(0), 3'b001, 7'b0010111, 16, 8, 8, '1, '0, '0, '0, '1,
           1'b1, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
    run_op(f6_of(0), 3'b010, 7'b1010111, 16, 8, 8, '1, '0, '0, '0, '1,
           1'b1, 0, 1'b0, 1'b1, 1'b0, 1'b0, "R1");
    run_op(6'b000000, 3'b101, 7'b1010111, 32, 4, 4, '1, '0, '0, '0, '1,
           1'b1, 0, 1'b1, 1'b1, 1'b0, 1'b0, "R1");
    run_op(f6_of(5), 3'b001, 7'b1010111, 64, 2, 2, '1, '0, '0, '0, '1,
           1'b1, 5, 1'b0, 1'b1, 1'b0, 1'b0, "R2");

    // R10: a start while busy is ignored.
    s2 = '0;
    for (int j = 0; j < 8; j++) s2 = s2 | (VLEN'(pool_val(16, j)) << (j * 16));
    run_op(f6_of(3), 3'b101, 7'b1010111, 16, 6, 8, s2, '0, pool_val(16, 2), '0, 8'hA5,
           1'b1, 3, 1'b1, 1'b0, 1'b1, 1'b1, "R10");

    summary();
  end

endmodule